// File: doc/BRIEF.md
# Programmable-Field GF(2^m) Multiply-Add Engine

This block multiplies two elements of a binary extension field GF(2^m) one multiplier bit per clock and adds a third operand to the product. Addition in this field is a bitwise XOR. The field degree m, which may be anywhere from 1 up to the datapath width, and the reduction polynomial are held in configuration registers. They are not supplied with each operation. Each step of the shift-and-add loop reduces the running multiplicand at once, so no wide intermediate product is ever formed.

A caller first loads the degree and the polynomial through a small write port while the engine is idle. It then presents operands A, C and B with a start pulse. When the done pulse arrives, the caller reads (A·C mod P) XOR B. A paired-output mode writes the same value to a second result port as well. It serves the butterfly step of a number-theoretic transform, which needs both the sum and the difference of a product and a third value, and in characteristic two those two values are equal. With both written in one operation, the butterfly needs no scratch register.

Top module: `gf_muladd_unit`

## Requirements
- R1: After reset, busy, done, res_sum and res_diff are all zero, and the stored field configuration is degree 8 with polynomial 0x11B.
- R2: A write with cfg_we high stores cfg_deg and cfg_poly at the next clock edge. This happens only when the engine is idle and 1 <= cfg_deg <= W. A write while busy, or a write with a degree outside that range, leaves the configuration unchanged. cfg_poly includes its bit-m term.
- R3: An operation returns res_sum = (A·C reduced modulo the stored polynomial) XOR B. With degree 8 and polynomial 0x11B, 0x80·0x83 gives 0x01.
- R4: Bits of opa, opc and opb at position m and above have no effect on the result or on the latency.
- R5: A start sampled while the engine is idle raises busy on the next cycle. Busy stays high for N cycles, where N is one more than the index of the highest set bit of the masked C, and N is 1 when the masked C is zero. In the cycle after the last busy cycle, done is high for exactly one cycle and busy is low.
- R6: A start sampled while busy is ignored. Its operands do not alter the running operation.
- R7: When twin is high at start, res_diff receives the same value as res_sum at completion. When twin is low, res_diff keeps its previous value.
- R8: res_sum and res_diff change only in the cycle in which done is high.
- R9: The full-width degree m = W works, including reduction through bit position W of the polynomial. The smallest degree, m = 1, also works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_deg | input | DW | Field degree m to store |
| cfg_poly | input | W+1 | Reduction polynomial including bit m |
| start | input | 1 | Begin an operation (idle only) |
| twin | input | 1 | Also write the result to res_diff |
| opa | input | W | Multiplicand A |
| opc | input | W | Multiplier C |
| opb | input | W | Addend B |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_sum | output | W | Product plus B |
| res_diff | output | W | Product minus B (twin mode) |

## Verification
The bench runs the 0x80·0x83 field product with high garbage bits on the operands. A design that failed to mask those bits would return a wrong value or run past eight cycles. Configuration writes are attempted while busy and with degrees of 0 and above W, and a design that accepted any of them would change the field seen by the next product. The bench exercises degree 64, where the reduction bit sits outside the operand width, and degree 1, where the product reduces to an AND. A multiplier of zero must still finish after one cycle and return B. A second start issued mid-operation must not disturb the result. In the non-paired mode, res_diff must hold its previous value, and a design that always wrote it would fail that check.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
  typedef enum logic {
    GFM_IDLE = 1'b0,
    GFM_RUN  = 1'b1
  } gfm_state_e;
endpackage

// File: rtl/gfm_cfg.sv
module gfm_cfg #(
  parameter int W  = 64,
  parameter int DW = $clog2(W + 1),
  parameter logic [DW-1:0] RST_DEG  = 8,
  parameter logic [W:0]    RST_POLY = 'h11B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_deg,
  input  logic [W:0]    wr_poly,
  output logic [DW-1:0] deg,
  output logic [W:0]    poly,
  output logic [W-1:0]  mask
);
  localparam logic [DW-1:0] DEG_MAX = DW'(W);

  logic          deg_ok;
  logic          cfg_en;
  logic [DW-1:0] deg_d, deg_q;
  logic [W:0]    poly_d, poly_q;

  assign deg_ok = (wr_deg != '0) && (wr_deg <= DEG_MAX);
  assign cfg_en = wr_en && deg_ok;

  always_comb begin
    deg_d  = deg_q;
    poly_d = poly_q;
    if (cfg_en) begin
      deg_d  = wr_deg;
      poly_d = wr_poly;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deg_q  <= RST_DEG;
      poly_q <= RST_POLY;
    end else begin
      deg_q  <= deg_d;
      poly_q <= poly_d;
    end
  end

  // bit i of the operand mask is live when i < m
  for (genvar i = 0; i < W; i++) begin : g_mask
    assign mask[i] = (deg_q > DW'(i));
  end

  assign deg  = deg_q;
  assign poly = poly_q;
endmodule

// File: rtl/gfm_step.sv
module gfm_step #(
  parameter int W  = 64,
  parameter int DW = $clog2(W + 1)
) (
  input  logic [W-1:0]  mcand,
  input  logic [W-1:0]  mplier,
  input  logic [W-1:0]  acc,
  input  logic [DW-1:0] deg,
  input  logic [W:0]    poly,
  input  logic [W-1:0]  mask,
  output logic [W-1:0]  mcand_nx,
  output logic [W-1:0]  mplier_nx,
  output logic [W-1:0]  acc_nx
);
  logic [W:0] shifted;
  logic [W:0] reduced;
  logic       overflow;

  // conditional accumulate on the multiplier LSB
  assign acc_nx = mplier[0] ? (acc ^ mcand) : acc;

  // double the multiplicand and fold back bit m
  assign shifted  = {mcand, 1'b0};
  assign overflow = shifted[deg];
  assign reduced  = overflow ? (shifted ^ poly) : shifted;
  assign mcand_nx = reduced[W-1:0] & mask;

  assign mplier_nx = {1'b0, mplier[W-1:1]};
endmodule

// File: rtl/gfm_ctrl.sv
module gfm_ctrl
  import gfm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic last,
  output logic busy,
  output logic load,
  output logic finish
);
  gfm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    finish  = 1'b0;
    unique case (state_q)
      GFM_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_d = GFM_RUN;
        end
      end
      GFM_RUN: begin
        if (last) begin
          finish  = 1'b1;
          state_d = GFM_IDLE;
        end
      end
      default: state_d = GFM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GFM_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q == GFM_RUN);
endmodule

// File: rtl/gf_muladd_unit.sv
module gf_muladd_unit #(
  parameter int W  = 64,
  parameter int DW = $clog2(W + 1),
  parameter logic [DW-1:0] RST_DEG  = 8,
  parameter logic [W:0]    RST_POLY = 'h11B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [DW-1:0] cfg_deg,
  input  logic [W:0]    cfg_poly,
  input  logic          start,
  input  logic          twin,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opc,
  input  logic [W-1:0]  opb,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  res_sum,
  output logic [W-1:0]  res_diff
);
  logic [DW-1:0] deg;
  logic [W:0]    poly;
  logic [W-1:0]  mask;
  logic          load, finish, last;

  logic [W-1:0] mcand_q, mcand_d, mcand_nx;
  logic [W-1:0] mplier_q, mplier_d, mplier_nx;
  logic [W-1:0] acc_q, acc_d, acc_nx;
  logic [W-1:0] addend_q, addend_d;
  logic         twin_q, twin_d;
  logic [W-1:0] sum_q, sum_d;
  logic [W-1:0] diff_q, diff_d;
  logic         done_q, done_d;

  gfm_cfg #(.W(W), .DW(DW), .RST_DEG(RST_DEG), .RST_POLY(RST_POLY)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we && !busy),
    .wr_deg  (cfg_deg),
    .wr_poly (cfg_poly),
    .deg     (deg),
    .poly    (poly),
    .mask    (mask)
  );

  gfm_step #(.W(W), .DW(DW)) u_step (
    .mcand     (mcand_q),
    .mplier    (mplier_q),
    .acc       (acc_q),
    .deg       (deg),
    .poly      (poly),
    .mask      (mask),
    .mcand_nx  (mcand_nx),
    .mplier_nx (mplier_nx),
    .acc_nx    (acc_nx)
  );

  assign last = (mplier_nx == '0);

  gfm_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .last   (last),
    .busy   (busy),
    .load   (load),
    .finish (finish)
  );

  always_comb begin
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    acc_d    = acc_q;
    addend_d = addend_q;
    twin_d   = twin_q;
    sum_d    = sum_q;
    diff_d   = diff_q;
    done_d   = finish;
    if (load) begin
      mcand_d  = opa & mask;
      mplier_d = opc & mask;
      acc_d    = '0;
      addend_d = opb & mask;
      twin_d   = twin;
    end else if (busy) begin
      mcand_d  = mcand_nx;
      mplier_d = mplier_nx;
      acc_d    = acc_nx;
      if (finish) begin
        sum_d = acc_nx ^ addend_q;
        if (twin_q) diff_d = acc_nx ^ addend_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
      addend_q <= '0;
      twin_q   <= 1'b0;
      sum_q    <= '0;
      diff_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      acc_q    <= acc_d;
      addend_q <= addend_d;
      twin_q   <= twin_d;
      sum_q    <= sum_d;
      diff_q   <= diff_d;
      done_q   <= done_d;
    end
  end

  assign done     = done_q;
  assign res_sum  = sum_q;
  assign res_diff = diff_q;
endmodule

// File: rtl/gfm_chk.sv
module gfm_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] res_sum,
  input logic [W-1:0] res_diff
);
  localparam int CW = $clog2(W + 2);
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R5
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R5
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CW'(W));

  // R8
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_sum) |-> done);

  // R8
  diff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_diff) |-> done);
endmodule

bind gf_muladd_unit gfm_chk #(.W(W)) u_gfm_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .res_sum  (res_sum),
  .res_diff (res_diff)
);

// File: tb/test_gf_muladd_unit.sv
module test_gf_muladd_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 64;
  localparam int DW = $clog2(W + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [DW-1:0] cfg_deg;
  logic [W:0]    cfg_poly;
  logic          start, twin;
  logic [W-1:0]  opa, opc, opb;
  logic          busy, done;
  logic [W-1:0]  res_sum, res_diff;

  int checks = 0;
  int errors = 0;
  int          m_deg;
  logic [W:0]  m_poly;
  logic [W-1:0] m_diff;

  always #(CLK_PERIOD/2) clk = ~clk;

  gf_muladd_unit #(.W(W)) i_gf_muladd_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_deg(cfg_deg),
    .cfg_poly(cfg_poly), .start(start), .twin(twin), .opa(opa), .opc(opc),
    .opb(opb), .busy(busy), .done(done), .res_sum(res_sum), .res_diff(res_diff)
  );

  function automatic logic [W-1:0] fmask(int d);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (i < d);
    return r;
  endfunction

  function automatic logic [W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] c,
                                           int d, logic [W:0] p);
    logic [W:0]   p1;
    logic [W-1:0] p2, acc;
    p1  = {1'b0, a & fmask(d)};
    p2  = c & fmask(d);
    acc = '0;
    while (p2 != '0) begin
      if (p2[0]) acc = acc ^ p1[W-1:0];
      p1 = p1 << 1;
      if (p1[d]) p1 = p1 ^ p;
      p1 = p1 & {1'b0, fmask(d)};
      p2 = p2 >> 1;
    end
    return acc;
  endfunction

  function automatic int ref_lat(logic [W-1:0] c, int d);
    logic [W-1:0] x;
    int n;
    x = c & fmask(d);
    n = 1;
    for (int i = 0; i < W; i++) if (x[i]) n = i + 1;
    return n;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(int d, logic [W:0] p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_deg = DW'(d); cfg_poly = p;
    if (!busy && d >= 1 && d <= W) begin m_deg = d; m_poly = p; end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // runs one operation; intrude=1 pulses a second start mid-run (R6)
  task automatic run_op(logic [W-1:0] a, logic [W-1:0] c, logic [W-1:0] b,
                        logic tw, bit intrude, string req);
    logic [W-1:0] exp_s;
    int exp_n, n;
    exp_s = ref_mul(a, c, m_deg, m_poly) ^ (b & fmask(m_deg));
    exp_n = ref_lat(c, m_deg);
    @(negedge clk);
    start = 1'b1; twin = tw; opa = a; opc = c; opb = b;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R5", "busy after start", W'(busy), W'(1));
    if (intrude) begin
      start = 1'b1; opa = ~a; opc = ~c; opb = ~b; twin = ~tw;
    end
    n = 1;
    while (done !== 1'b1 && n < 200) begin
      @(negedge clk);
      start = 1'b0;
      if (done !== 1'b1) n++;
    end
    chk(n == exp_n, "R5", "latency", W'(n), W'(exp_n));
    chk(busy === 1'b0, "R5", "busy low at done", W'(busy), W'(0));
    chk(res_sum === exp_s, req, "res_sum", res_sum, exp_s);
    if (tw) m_diff = exp_s;
    chk(res_diff === m_diff, "R7", "res_diff", res_diff, m_diff);
    @(negedge clk);
    chk(done === 1'b0, "R5", "done single pulse", W'(done), W'(0));
    chk(res_sum === exp_s, "R8", "res_sum held", res_sum, exp_s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_deg = '0; cfg_poly = '0;
    start = 1'b0; twin = 1'b0; opa = '0; opc = '0; opb = '0;
    m_deg = 8; m_poly = 'h11B; m_diff = '0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done at reset", W'({busy, done}), '0);
    chk(res_sum === '0 && res_diff === '0, "R1", "results at reset", res_sum | res_diff, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3: reset field is degree 8 / 0x11B, 0x80*0x83 = 0x01
    run_op('h80, 'h83, '0, 1'b1, 1'b0, "R3");
    chk(res_sum === 'h1, "R3", "known field product", res_sum, 'h1);
    // R4: high garbage bits on every operand
    run_op('hDEAD_0080, 'hBEEF_0083, 'hF00, 1'b0, 1'b0, "R4");
    chk(res_sum === 'h1, "R4", "masked product", res_sum, 'h1);
    // zero multiplier: one cycle, result is B
    run_op('h57, '0, 'h3C, 1'b1, 1'b0, "R3");
    // R6: second start during run is ignored
    run_op('hC3, 'hF1, 'h11, 1'b1, 1'b1, "R6");
    // R2: invalid degrees ignored
    write_cfg(0, 'h3);
    write_cfg(100, 'h3);
    run_op('h80, 'h83, '0, 1'b0, 1'b0, "R2");
    chk(res_sum === 'h1, "R2", "invalid degree ignored", res_sum, 'h1);
    // R2: write while busy ignored
    @(negedge clk);
    start = 1'b1; opa = 'h5; opc = 'hFF; opb = '0; twin = 1'b0;
    @(negedge clk);
    start = 1'b0; cfg_we = 1'b1; cfg_deg = 13; cfg_poly = 'h201B;
    @(negedge clk);
    cfg_we = 1'b0;
    while (busy === 1'b1) @(negedge clk);
    @(negedge clk);
    run_op('h80, 'h83, '0, 1'b0, 1'b0, "R2");
    chk(res_sum === 'h1, "R2", "busy write ignored", res_sum, 'h1);

    for (int i = 0; i < 12; i++)
      run_op(W'($urandom), W'($urandom), W'($urandom), 1'($urandom), 1'b0, "R3");

    write_cfg(13, 'h201B);
    for (int i = 0; i < 12; i++)
      run_op({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
             1'($urandom), 1'b0, "R3");

    // R9: full width degree
    write_cfg(64, {1'b1, 64'h1B});
    run_op(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, 64'h1, 1'b1, 1'b0, "R9");
    for (int i = 0; i < 10; i++)
      run_op({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
             1'($urandom), 1'b0, "R9");

    // R9: smallest degree, product is a AND c
    write_cfg(1, 'h3);
    run_op('hFFFF, 'h7, 'h0, 1'b1, 1'b0, "R9");
    chk(res_sum === 'h1, "R9", "degree 1 product", res_sum, 'h1);
    run_op('h2, 'h3, 'h1, 1'b0, 1'b0, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule